// File: doc/BRIEF.md
# Rotate, Shift and Mask Unit

A 64-bit datapath element for an integer pipeline that covers every rotate-under-mask, rotate-and-insert, logical shift, arithmetic shift and sign-extend-then-shift operation with a single left rotator and a single mask generator. Six control flags choose the variant: word or doubleword width, right or left direction, sign fill, clearing of high-order bits, clearing of low-order bits, and sign extension of the source's low word. The mask bounds for the masked forms are taken from fixed fields of a 32-bit instruction word. The shift forms take their bounds from the shift amount instead.

The arithmetic is a single combinational stage. Its result and carry are captured in output registers, so a result appears on the rising edge that follows the cycle in which its inputs were applied. The registers clear under a synchronous active-high reset.

Bit positions below are counted two ways. "Bit" means the ordinary index, where bit 0 is the least significant. "Position k" means the k-th bit counting down from the most significant bit of the 64-bit result, so position 0 is bit 63 and position 63 is bit 0. A mask from position b to position e covers b..e when b <= e. When b > e it wraps and covers b..63 together with 0..e.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_o` and `carry_o` become 0 at that edge whatever the other inputs are. Otherwise every result and carry appears at the rising edge that follows the cycle in which the inputs were held.
- R2: Word masked rotate (`op_word`=1, `op_clr_hi`=1, `op_clr_lo`=1). The low 32 bits of `src_i` are rotated left by `shamt_i[4:0]` and copied into both halves. The result keeps the positions in the mask from 32+`insn_i[10:6]` to 32+`insn_i[5:1]`. When the begin field exceeds the end field, the mask wraps into the upper half.
- R3: When both clear flags are set, in either width, every result bit outside the mask is taken from `ins_i`. A zero `ins_i` therefore gives rotate-and-AND, and a live `ins_i` gives rotate-and-insert.
- R4: Doubleword with only `op_clr_hi`. `src_i` is rotated left by `shamt_i[5:0]`, and positions 0 up to (but not including) position f are cleared, where f = {`insn_i[5]`, `insn_i[10:6]`}. `ins_i` has no effect.
- R5: Doubleword with only `op_clr_lo`. `src_i` is rotated left by `shamt_i[5:0]`, and the positions after position f are cleared, with f as in R4. `ins_i` has no effect.
- R6: Doubleword with both clear flags. The rotate is by `shamt_i[5:0]`, and the mask runs from position f (as in R4) to position 63-`shamt_i[5:0]`, wrapping when f is the larger.
- R7: Logical left shift (no clear flag, `op_right`=0, `op_arith`=0) uses all 7 bits of `shamt_i`. The result is 0 once the amount is at least 32 for a word or at least 64 for a doubleword. A word result occupies bits 31:0 and has bits 63:32 zero.
- R8: Logical right shift (no clear flag, `op_right`=1) follows the same 7-bit amount and zero rule as R7. The word form shifts only the low 32 bits of `src_i`.
- R9: Arithmetic right shift (`op_right`=1, `op_arith`=1, no clear flag) fills every vacated bit, and for the word form all of bits 63:32, with the sign bit: bit 31 for a word, bit 63 for a doubleword. An amount at or beyond the width gives all sign bits.
- R10: For an arithmetic right shift, `carry_o` is 1 exactly when the operand is negative and at least one 1 bit was shifted out of the operand. Once the amount reaches the width, all operand bits count as shifted out.
- R11: Doubleword left shift with `op_sext`=1. Bits 63:32 of `src_i` are replaced by copies of bit 31 before the shift. An amount of 64 or more gives 0.
- R12: `carry_o` is 0 for every operation other than an arithmetic right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Source operand to rotate or shift |
| ins_i | input | 64 | Insert operand, used outside the mask when both clear flags are set |
| shamt_i | input | 7 | Shift or rotate amount |
| insn_i | input | 32 | Instruction word carrying the mask-begin and mask-end fields |
| op_word | input | 1 | 1 selects the 32-bit form |
| op_right | input | 1 | 1 selects a right shift |
| op_arith | input | 1 | 1 selects sign fill and carry for right shifts |
| op_clr_hi | input | 1 | Clear the high-order positions before the mask begin |
| op_clr_lo | input | 1 | Clear the low-order positions after the mask end |
| op_sext | input | 1 | Sign-extend the source's low word before a doubleword left shift |
| res_o | output | 64 | Registered result |
| carry_o | output | 1 | Registered carry for arithmetic right shifts |

## Verification
During an arithmetic right shift the unit must produce two things in the same cycle: the sign fill of the vacated bits and the carry that records lost 1 bits. A wrong carry can hide behind a correct result, and the reverse is also possible. Negative and positive operands are shifted by amounts with and without 1 bits below the cut, including amounts at and beyond the width. Each scoreboard entry holds the expected result and carry together, and one compare judges both. Wrapping masks combined with a live insert operand exercise mask generation and merging in the same cycle.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  // Instruction field placement for the mask bounds
  localparam int MB_FLD_LSB = 6;   // begin field, low five bits
  localparam int ME_FLD_LSB = 1;   // word end field
  localparam int MB_HI_BIT  = 5;   // sixth bit of the doubleword field

  typedef struct packed {
    logic word;
    logic right;
    logic arith;
    logic clr_hi;
    logic clr_lo;
    logic sext;
  } rm_ctl_t;

endpackage

// File: rtl/rm_bounds.sv
module rm_bounds
  import rotmask_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7,
  parameter int INSN_W  = 32,
  localparam int RW     = $clog2(DATA_W)
) (
  input  rm_ctl_t              ctl,
  input  logic [SHAMT_W-1:0]   shamt,
  input  logic [INSN_W-1:0]    insn,
  output logic [RW-1:0]        rot_amt,
  output logic [RW-1:0]        mb,
  output logic [RW-1:0]        me,
  output logic                 off
);

  localparam int FW = RW - 1;
  localparam int HW = DATA_W / 2;
  localparam logic [RW-1:0] TOP  = RW'(DATA_W - 1);
  localparam logic [RW-1:0] HALF = RW'(HW);

  logic [FW-1:0] f_mb, f_me, sh5;
  logic          f_hi;
  logic [RW-1:0] sh6, fld6;
  logic          plain, too_far;
  logic          unused_insn;

  assign f_mb = insn[MB_FLD_LSB +: FW];
  assign f_me = insn[ME_FLD_LSB +: FW];
  assign f_hi = insn[MB_HI_BIT];
  assign fld6 = {f_hi, f_mb};
  assign sh6  = shamt[RW-1:0];
  assign sh5  = shamt[FW-1:0];
  assign unused_insn = ^insn;

  assign plain   = !ctl.clr_hi && !ctl.clr_lo;
  assign too_far = ctl.word ? (shamt >= SHAMT_W'(HW)) : (shamt >= SHAMT_W'(DATA_W));

  // right shifts become left rotates by the negated amount
  assign rot_amt = ctl.right ? (RW'(0) - sh6) : sh6;
  assign off     = plain && too_far;

  always_comb begin
    if (ctl.clr_hi)
      mb = ctl.word ? (HALF + RW'(f_mb)) : fld6;
    else if (ctl.right)
      mb = ctl.word ? (HALF + RW'(sh5)) : sh6;
    else
      mb = ctl.word ? HALF : '0;
  end

  always_comb begin
    if (ctl.clr_lo) begin
      if (ctl.word)
        me = HALF + RW'(f_me);
      else if (!ctl.clr_hi)
        me = fld6;
      else
        me = TOP - sh6;
    end else if (!ctl.clr_hi && !ctl.right) begin
      me = ctl.word ? (TOP - RW'(sh5)) : (TOP - sh6);
    end else begin
      me = TOP;
    end
  end

endmodule

// File: rtl/rm_maskgen.sv
module rm_maskgen #(
  parameter int DATA_W = 64,
  localparam int RW    = $clog2(DATA_W)
) (
  input  logic [RW-1:0]     mb,
  input  logic [RW-1:0]     me,
  input  logic              off,
  output logic [DATA_W-1:0] mask
);

  localparam logic [RW-1:0] TOP = RW'(DATA_W - 1);

  logic [DATA_W-1:0] from_mb, to_me;
  logic              wrap;

  // positions counted from the MSB: mb..end and 0..me as thermometers
  assign from_mb = {DATA_W{1'b1}} >> mb;
  assign to_me   = {DATA_W{1'b1}} << (TOP - me);
  assign wrap    = mb > me;

  assign mask = off  ? '0 :
                wrap ? (from_mb | to_me) : (from_mb & to_me);

endmodule

// File: rtl/rm_rotl.sv
module rm_rotl #(
  parameter int DATA_W = 64,
  localparam int RW    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [RW-1:0]     amt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [0:RW];

  assign stage[0] = din;

  for (genvar k = 0; k < RW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][DATA_W-1-S:0], stage[k][DATA_W-1 -: S]}
                               : stage[k];
  end

  assign dout = stage[RW];

endmodule

// File: rtl/rm_carry.sv
module rm_carry #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7
) (
  input  logic [DATA_W-1:0]  src,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic               word,
  input  logic               en,
  output logic               sign,
  output logic               cy
);

  localparam int HW = DATA_W / 2;

  logic [DATA_W-1:0] below, width_m;

  // bits below the shift point leave the operand; wide amounts drop all
  assign below   = ~({DATA_W{1'b1}} << shamt);
  assign width_m = word ? {{HW{1'b0}}, {HW{1'b1}}} : {DATA_W{1'b1}};
  assign sign    = word ? src[HW-1] : src[DATA_W-1];
  assign cy      = en && sign && (|(src & below & width_m));

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7,
  parameter int INSN_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  src_i,
  input  logic [DATA_W-1:0]  ins_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [INSN_W-1:0]  insn_i,
  input  logic               op_word,
  input  logic               op_right,
  input  logic               op_arith,
  input  logic               op_clr_hi,
  input  logic               op_clr_lo,
  input  logic               op_sext,
  output logic [DATA_W-1:0]  res_o,
  output logic               carry_o
);

  localparam int HW = DATA_W / 2;
  localparam int RW = $clog2(DATA_W);

  rm_ctl_t           ctl;
  logic [DATA_W-1:0] src_rot, rotated, mask, fill, merge_src, res_n;
  logic [RW-1:0]     amt, mb, me;
  logic              off, plain, shr_arith, sign, cy_n;

  assign ctl = '{word: op_word, right: op_right, arith: op_arith,
                 clr_hi: op_clr_hi, clr_lo: op_clr_lo, sext: op_sext};

  // word forms rotate a duplicated low word so wrapped masks see it twice
  assign src_rot = op_word ? {2{src_i[HW-1:0]}} :
                   op_sext ? {{HW{src_i[HW-1]}}, src_i[HW-1:0]} : src_i;

  assign plain     = !op_clr_hi && !op_clr_lo;
  assign shr_arith = plain && op_arith && op_right;

  rm_bounds #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .INSN_W(INSN_W)) u_bounds (
    .ctl     (ctl),
    .shamt   (shamt_i),
    .insn    (insn_i),
    .rot_amt (amt),
    .mb      (mb),
    .me      (me),
    .off     (off)
  );

  rm_rotl #(.DATA_W(DATA_W)) u_rotl (
    .din  (src_rot),
    .amt  (amt),
    .dout (rotated)
  );

  rm_maskgen #(.DATA_W(DATA_W)) u_mask (
    .mb   (mb),
    .me   (me),
    .off  (off),
    .mask (mask)
  );

  rm_carry #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_carry (
    .src   (src_i),
    .shamt (shamt_i),
    .word  (op_word),
    .en    (shr_arith),
    .sign  (sign),
    .cy    (cy_n)
  );

  assign fill      = shr_arith ? {DATA_W{sign}} : '0;
  assign merge_src = (op_clr_hi && op_clr_lo) ? ins_i : '0;
  assign res_n     = (rotated & mask) | (~mask & (merge_src | fill));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      res_o   <= res_n;
      carry_o <= cy_n;
    end
  end

endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int SHAMT_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic [DATA_W-1:0]  src_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic               op_word,
  input logic               op_right,
  input logic               op_arith,
  input logic               op_clr_hi,
  input logic               op_clr_lo,
  input logic [DATA_W-1:0]  res_o,
  input logic               carry_o
);

  localparam int HW = DATA_W / 2;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && carry_o == 1'b0));

  // R12
  carry_only_sra_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> $past(op_arith && op_right && !op_clr_hi && !op_clr_lo));

  // R10
  carry_needs_sign_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |-> $past(op_word ? src_i[HW-1] : src_i[DATA_W-1]));

  // R7
  shift_past_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_clr_hi && !op_clr_lo && !op_arith &&
     (op_word ? (shamt_i >= SHAMT_W'(HW)) : (shamt_i >= SHAMT_W'(DATA_W))))
    |=> (res_o == '0));

  // R7
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_word && !op_arith && !op_clr_hi && !op_clr_lo) |=> (res_o[DATA_W-1:HW] == '0));

  // R9
  sra_top_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (op_arith && op_right && !op_clr_hi && !op_clr_lo)
    |=> (res_o[DATA_W-1] == $past(op_word ? src_i[HW-1] : src_i[DATA_W-1])));

endmodule

bind rotmask_unit rotmask_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_i     (src_i),
  .shamt_i   (shamt_i),
  .op_word   (op_word),
  .op_right  (op_right),
  .op_arith  (op_arith),
  .op_clr_hi (op_clr_hi),
  .op_clr_lo (op_clr_lo),
  .res_o     (res_o),
  .carry_o   (carry_o)
);

// File: tb/tb_rotmask_unit.sv
`timescale 1ns/1ps
module tb_rotmask_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0, ins_i = '0;
  logic [6:0]  shamt_i = '0;
  logic [31:0] insn_i = '0;
  logic        op_word = 0, op_right = 0, op_arith = 0;
  logic        op_clr_hi = 0, op_clr_lo = 0, op_sext = 0;
  logic [63:0] res_o;
  logic        carry_o;

  always #4 clk = ~clk;

  rotmask_unit dut (
    .clk(clk), .rst(rst), .src_i(src_i), .ins_i(ins_i), .shamt_i(shamt_i),
    .insn_i(insn_i), .op_word(op_word), .op_right(op_right), .op_arith(op_arith),
    .op_clr_hi(op_clr_hi), .op_clr_lo(op_clr_lo), .op_sext(op_sext),
    .res_o(res_o), .carry_o(carry_o)
  );

  // control order {word, right, arith, clr_hi, clr_lo, sext}
  localparam logic [5:0] K_RLW   = 6'b100110;
  localparam logic [5:0] K_RLDB  = 6'b000110;
  localparam logic [5:0] K_RLDHI = 6'b000100;
  localparam logic [5:0] K_RLDLO = 6'b000010;
  localparam logic [5:0] K_SLW   = 6'b100000;
  localparam logic [5:0] K_SLD   = 6'b000000;
  localparam logic [5:0] K_SRW   = 6'b110000;
  localparam logic [5:0] K_SRD   = 6'b010000;
  localparam logic [5:0] K_SRAW  = 6'b111000;
  localparam logic [5:0] K_SRAD  = 6'b011000;
  localparam logic [5:0] K_EXSL  = 6'b000001;

  typedef struct packed {
    logic [63:0] res;
    logic        cy;
    logic [3:0]  rq;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m;
    for (int p = 0; p < 64; p++)
      m[63-p] = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
    return m;
  endfunction

  function automatic logic [63:0] rotl64(input logic [63:0] x, input int n);
    int k = n % 64;
    if (k == 0) return x;
    return (x << k) | (x >> (64 - k));
  endfunction

  function automatic logic [31:0] mk_w(input int b, input int e);
    return {21'b0, 5'(b), 5'(e), 1'b0};
  endfunction

  function automatic logic [31:0] mk_d(input int f);
    logic [5:0] v = 6'(f);
    return {21'b0, v[4:0], v[5], 4'b0, 1'b0};
  endfunction

  task automatic ref_model(input logic [63:0] s, input logic [63:0] a, input logic [6:0] sh,
                           input logic [31:0] ins, input logic [5:0] ctl,
                           output logic [63:0] r, output logic c);
    int          n, mbw, mew, f6;
    logic [63:0] m, v, lost;
    logic [31:0] w, t;
    logic        sg;
    n   = int'(sh);
    mbw = int'(ins[10:6]);
    mew = int'(ins[5:1]);
    f6  = int'({ins[5], ins[10:6]});
    w   = s[31:0];
    c   = 1'b0;
    r   = '0;
    case (ctl)
      K_RLW: begin
        m = ref_mask(mbw + 32, mew + 32);
        r = (rotl64({w, w}, n % 32) & m) | (a & ~m);
      end
      K_RLDB: begin
        m = ref_mask(f6, 63 - (n % 64));
        r = (rotl64(s, n % 64) & m) | (a & ~m);
      end
      K_RLDHI: r = rotl64(s, n % 64) & ref_mask(f6, 63);
      K_RLDLO: r = rotl64(s, n % 64) & ref_mask(0, f6);
      K_SLW: begin
        t = w << n;
        r = (n >= 32) ? 64'h0 : {32'h0, t};
      end
      K_SLD: r = (n >= 64) ? 64'h0 : (s << n);
      K_SRW: r = (n >= 32) ? 64'h0 : {32'h0, w >> n};
      K_SRD: r = (n >= 64) ? 64'h0 : (s >> n);
      K_SRAW: begin
        sg = w[31];
        if (n >= 32) begin
          r = {64{sg}};
          c = sg && (w != 0);
        end else begin
          v = {{32{sg}}, w};
          r = 64'($signed(v) >>> n);
          lost = {32'h0, w} & ((64'h1 << n) - 64'h1);
          c = sg && (lost != 0);
        end
      end
      K_SRAD: begin
        sg = s[63];
        if (n >= 64) begin
          r = {64{sg}};
          c = sg && (s != 0);
        end else begin
          r = 64'($signed(s) >>> n);
          lost = s & ((64'h1 << n) - 64'h1);
          c = sg && (lost != 0);
        end
      end
      K_EXSL: r = (n >= 64) ? 64'h0 : ({{32{w[31]}}, w} << n);
      default: r = '0;
    endcase
  endtask

  // driver: applies one operation and queues its expected outcome
  task automatic drive(input logic [63:0] s, input logic [63:0] a, input logic [6:0] sh,
                       input logic [31:0] ins, input logic [5:0] ctl, input logic [3:0] rq);
    logic [63:0] r;
    logic        c;
    ref_model(s, a, sh, ins, ctl, r, c);
    @(negedge clk);
    src_i   = s;
    ins_i   = a;
    shamt_i = sh;
    insn_i  = ins;
    {op_word, op_right, op_arith, op_clr_hi, op_clr_lo, op_sext} = ctl;
    q.push_back('{res: r, cy: c, rq: rq});
  endtask

  task automatic rnd_block(input logic [5:0] ctl, input logic [3:0] rq, input int cnt,
                           input bit live_ins, input logic [6:0] shmask);
    for (int i = 0; i < cnt; i++) begin
      logic [63:0] s, a;
      s = {$urandom, $urandom};
      a = live_ins ? {$urandom, $urandom} : 64'h0;
      drive(s, a, 7'($urandom) & shmask, {21'b0, 10'($urandom), 1'b0}, ctl, rq);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares each queued expectation one cycle after its drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (res_o !== e.res || carry_o !== e.cy) begin
          errors++;
          $display("FAIL R%0d: res=%h carry=%b expected res=%h carry=%b",
                   e.rq, res_o, carry_o, e.res, e.cy);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset holds outputs at zero despite an operation that would carry
    src_i = 64'hFFFF_FFFF_FFFF_FFFF;
    shamt_i = 7'd5;
    {op_word, op_right, op_arith, op_clr_hi, op_clr_lo, op_sext} = K_SRAD;
    repeat (3) @(negedge clk);
    checks++;
    if (res_o !== 64'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: res=%h carry=%b expected res=%h carry=%b",
               res_o, carry_o, 64'h0, 1'b0);
    end
    rst = 1'b0;

    // R2: word rotate, wrapping and single-bit masks
    drive(64'hDEAD_BEEF_1234_5678, 64'h0, 7'd4,  mk_w(28, 3),  K_RLW, 4'd2);
    drive(64'hDEAD_BEEF_1234_5678, 64'h0, 7'd31, mk_w(0, 0),   K_RLW, 4'd2);
    drive(64'h0000_0000_8000_0001, 64'h0, 7'd65, mk_w(31, 31), K_RLW, 4'd2);
    rnd_block(K_RLW, 4'd2, 60, 1'b0, 7'h7F);
    // R3: insert from a live operand in both widths, with and without wrap
    drive(64'h0123_4567_89AB_CDEF, 64'hA5A5_A5A5_A5A5_A5A5, 7'd8, mk_w(8, 23), K_RLW, 4'd3);
    drive(64'h0123_4567_89AB_CDEF, 64'h5A5A_5A5A_5A5A_5A5A, 7'd10, mk_d(40), K_RLDB, 4'd3);
    drive(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 7'd20, mk_d(60), K_RLDB, 4'd3);
    rnd_block(K_RLW, 4'd3, 60, 1'b1, 7'h1F);
    rnd_block(K_RLDB, 4'd3, 60, 1'b1, 7'h3F);
    // R4: clear high positions, insert operand live but ignored
    drive(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 7'd12, mk_d(0),  K_RLDHI, 4'd4);
    drive(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 7'd12, mk_d(63), K_RLDHI, 4'd4);
    rnd_block(K_RLDHI, 4'd4, 60, 1'b1, 7'h7F);
    // R5: clear low positions, insert operand live but ignored
    drive(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 7'd3, mk_d(63), K_RLDLO, 4'd5);
    drive(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF, 7'd3, mk_d(0),  K_RLDLO, 4'd5);
    rnd_block(K_RLDLO, 4'd5, 60, 1'b1, 7'h7F);
    // R6: both clears, bit 6 of the amount ignored
    drive(64'h8000_0000_0000_0001, 64'h0, 7'd0,  mk_d(0),  K_RLDB, 4'd6);
    drive(64'h8000_0000_0000_0001, 64'h0, 7'd65, mk_d(62), K_RLDB, 4'd6);
    rnd_block(K_RLDB, 4'd6, 60, 1'b0, 7'h7F);
    // R7: logical left at and beyond the width
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd31,  32'h0, K_SLW, 4'd7);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd32,  32'h0, K_SLW, 4'd7);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd127, 32'h0, K_SLW, 4'd7);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd63,  32'h0, K_SLD, 4'd7);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd64,  32'h0, K_SLD, 4'd7);
    drive(64'h1234_5678_9ABC_DEF0, 64'h0, 7'd0,   32'h0, K_SLD, 4'd7);
    rnd_block(K_SLW, 4'd7, 60, 1'b1, 7'h7F);
    rnd_block(K_SLD, 4'd7, 60, 1'b1, 7'h7F);
    // R8: logical right
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd31, 32'h0, K_SRW, 4'd8);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd32, 32'h0, K_SRW, 4'd8);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd63, 32'h0, K_SRD, 4'd8);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd64, 32'h0, K_SRD, 4'd8);
    rnd_block(K_SRW, 4'd8, 60, 1'b1, 7'h7F);
    rnd_block(K_SRD, 4'd8, 60, 1'b1, 7'h7F);
    // R9: sign fill, including amounts past the width
    drive(64'h0000_0000_8000_0000, 64'h0, 7'd4,   32'h0, K_SRAW, 4'd9);
    drive(64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 7'd40,  32'h0, K_SRAW, 4'd9);
    drive(64'h8000_0000_0000_0000, 64'h0, 7'd127, 32'h0, K_SRAD, 4'd9);
    rnd_block(K_SRAW, 4'd9, 60, 1'b0, 7'h7F);
    rnd_block(K_SRAD, 4'd9, 60, 1'b0, 7'h7F);
    // R10: carry with and without lost 1 bits
    drive(64'h0000_0000_8000_0001, 64'h0, 7'd1,  32'h0, K_SRAW, 4'd10);
    drive(64'h0000_0000_8000_0001, 64'h0, 7'd0,  32'h0, K_SRAW, 4'd10);
    drive(64'h0000_0000_8000_0000, 64'h0, 7'd31, 32'h0, K_SRAW, 4'd10);
    drive(64'h0000_0000_8000_0000, 64'h0, 7'd32, 32'h0, K_SRAW, 4'd10);
    drive(64'h0000_0000_0000_00FF, 64'h0, 7'd5,  32'h0, K_SRAW, 4'd10);
    drive(64'h8000_0000_0000_0000, 64'h0, 7'd63, 32'h0, K_SRAD, 4'd10);
    drive(64'h8000_0000_0000_0000, 64'h0, 7'd64, 32'h0, K_SRAD, 4'd10);
    drive(64'hC000_0000_0000_0001, 64'h0, 7'd1,  32'h0, K_SRAD, 4'd10);
    rnd_block(K_SRAD, 4'd10, 60, 1'b0, 7'h0F);
    // R11: sign-extended left shift
    drive(64'h1234_5678_8000_0001, 64'h0, 7'd0,  32'h0, K_EXSL, 4'd11);
    drive(64'hFFFF_FFFF_7FFF_FFFF, 64'h0, 7'd4,  32'h0, K_EXSL, 4'd11);
    drive(64'h0000_0000_8000_0001, 64'h0, 7'd63, 32'h0, K_EXSL, 4'd11);
    drive(64'h0000_0000_8000_0001, 64'h0, 7'd64, 32'h0, K_EXSL, 4'd11);
    rnd_block(K_EXSL, 4'd11, 60, 1'b0, 7'h3F);
    // R12: negative operands under non-arithmetic forms never carry
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd7, 32'h0,       K_SRD,  4'd12);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd7, 32'h0,       K_SRW,  4'd12);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd7, mk_w(3, 20), K_RLW,  4'd12);
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 7'd7, mk_d(9),     K_RLDHI, 4'd12);

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule